// File: doc/BRIEF.md
# Per-Pin Stimulus Waveform Formatter

This block shapes the drive waveform of one tester pin. Time inside each vector period is counted in ticks of the block clock. For every period the block takes one vector: a data bit, a format code, a drive/receive flag, an expected bit and a compare mask. From these and three programmable tick positions (start of the active window, end of the window, compare strobe) it produces a pin drive value and a drive enable, tick by tick.

Five waveform shapes are supported. The held format changes the pin once per period at the window start. The pulse formats drive the bit only inside the window. The inhibit format releases the driver outside the window. The complement format surrounds the true bit with its inverse. A per-pin compare samples the pin input once per period at the strobe tick. A mismatch raises a sticky fail flag. The compare is masked on request, and it is skipped whenever the driver itself owns the pin at the strobe tick.

Vectors are fetched with a simple request: the block raises a request on the last tick of each period, and a vector offered in that tick becomes the current vector for the next period. Timing settings are checked when written, and an accepted write takes effect at the next period boundary.

Top module: `wavefmt_pin`

## Requirements
- R1: A tick counter runs from 0 to period−1 and then wraps. nextReq is high exactly on tick period−1. A vector presented with vecValid high during that tick is current for the whole following period, starting at tick 0.
- R2: Format code 0 (held), and any code above 4: before the window-start tick the pin shows the previous period's bit. From the window-start tick to the end of the period it shows the current bit.
- R3: Format code 1 (pulse high): pinOut is the data bit for ticks with start ≤ tick < end, and 0 for all other ticks.
- R4: Format code 2 (pulse low): pinOut is the data bit inside the window and 1 outside it, so a 0 bit gives a low pulse whose width is end minus start ticks.
- R5: Format code 3 (inhibit): pinOe is high only inside the window, where pinOut is the data bit.
- R6: Format code 4 (complement): pinOut is the data bit inside the window and its inverse outside it.
- R7: A vector with vecDrive = 0 (receive) keeps pinOe low for its whole period. While pinOe is low, pinOut is 0.
- R8: If no vector is offered during the request tick, the last vector is repeated for the next period.
- R9: A timing write is rejected when period < 2, start ≥ end, end > period, or strobe ≥ period. cfgErr then reads 1 from the following cycle and the old settings are kept. An accepted write clears cfgErr and takes effect at the next period boundary. cfgErr changes only on a write.
- R10: At the strobe tick, if a vector is loaded, vecMask of that vector is 0 and pinOe is low, a difference between pinIn and the expected bit sets failFlag. failFlag stays set until failClr is high for a cycle with no new mismatch.
- R11: After reset the settings are period 8, start 2, end 5, strobe 6. pinOe, nextReq, failFlag and cfgErr are low, and no drive or compare takes place until the first vector has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWrite | input | 1 | Write strobe for the timing settings |
| cfgPeriod | input | TICK_W | Ticks per vector period |
| cfgLead | input | TICK_W | Window start tick |
| cfgTrail | input | TICK_W | Window end tick (exclusive) |
| cfgStrobe | input | TICK_W | Compare strobe tick |
| cfgErr | output | 1 | Last timing write was rejected |
| vecValid | input | 1 | A vector is offered |
| vecBit | input | 1 | Stimulus data bit |
| vecFmt | input | 3 | Format code |
| vecDrive | input | 1 | 1 = drive this period, 0 = receive |
| vecExpect | input | 1 | Expected pin value at the strobe |
| vecMask | input | 1 | 1 = no compare this period |
| nextReq | output | 1 | Request for the next vector (last tick) |
| pinOut | output | 1 | Drive value |
| pinOe | output | 1 | Drive enable |
| pinIn | input | 1 | Sensed pin value |
| failClr | input | 1 | Synchronous clear of failFlag |
| failFlag | output | 1 | Sticky compare failure |

## Verification
A wrong tick count or a stale timing register shifts the window edges. This shows within one period as a pinOut or pinOe edge on the wrong tick, or as nextReq on the wrong tick. The bench compares every tick of every period against a model that it keeps itself. A wrong previous-bit or repeat register shows on the held format before the window start of the next period. A fault in the compare path shows as failFlag at the last tick of the period that holds the strobe.

// File: rtl/wavefmt_pkg.sv
package wavefmt_pkg;
  typedef enum logic [2:0] {
    FMT_HELD  = 3'd0,
    FMT_PHIGH = 3'd1,
    FMT_PLOW  = 3'd2,
    FMT_INH   = 3'd3,
    FMT_CMPL  = 3'd4
  } fmt_e;

  typedef struct packed {
    logic boundary;
    logic pastLead;
    logic inWin;
    logic strobeTick;
  } tickCtl_t;
endpackage

// File: rtl/wavefmt_ctrl.sv
module wavefmt_ctrl
  import wavefmt_pkg::*;
#(
  parameter int TICK_W     = 8,
  parameter int DEF_PERIOD = 8,
  parameter int DEF_LEAD   = 2,
  parameter int DEF_TRAIL  = 5,
  parameter int DEF_STROBE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrite,
  input  logic [TICK_W-1:0] cfgPeriod,
  input  logic [TICK_W-1:0] cfgLead,
  input  logic [TICK_W-1:0] cfgTrail,
  input  logic [TICK_W-1:0] cfgStrobe,
  output logic              cfgErr,
  output logic              nextReq,
  output tickCtl_t          ctl
);
  localparam logic [TICK_W-1:0] ONE     = TICK_W'(1);
  localparam logic [TICK_W-1:0] MIN_PER = TICK_W'(2);

  logic [TICK_W-1:0] cnt;
  logic [TICK_W-1:0] actPeriod, actLead, actTrail, actStrobe;
  logic [TICK_W-1:0] shPeriod, shLead, shTrail, shStrobe;
  logic lastTick, cfgBad;

  assign lastTick = (cnt == actPeriod - ONE);
  assign cfgBad   = (cfgPeriod < MIN_PER) || (cfgLead >= cfgTrail) ||
                    (cfgTrail > cfgPeriod) || (cfgStrobe >= cfgPeriod);

  // tick counter; active settings swap only at a period boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      actPeriod <= TICK_W'(DEF_PERIOD);
      actLead   <= TICK_W'(DEF_LEAD);
      actTrail  <= TICK_W'(DEF_TRAIL);
      actStrobe <= TICK_W'(DEF_STROBE);
    end else if (lastTick) begin
      cnt       <= '0;
      actPeriod <= shPeriod;
      actLead   <= shLead;
      actTrail  <= shTrail;
      actStrobe <= shStrobe;
    end else begin
      cnt <= cnt + ONE;
    end
  end

  // shadow settings with write validation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shPeriod <= TICK_W'(DEF_PERIOD);
      shLead   <= TICK_W'(DEF_LEAD);
      shTrail  <= TICK_W'(DEF_TRAIL);
      shStrobe <= TICK_W'(DEF_STROBE);
      cfgErr   <= 1'b0;
    end else if (cfgWrite) begin
      cfgErr <= cfgBad;
      if (!cfgBad) begin
        shPeriod <= cfgPeriod;
        shLead   <= cfgLead;
        shTrail  <= cfgTrail;
        shStrobe <= cfgStrobe;
      end
    end
  end

  assign nextReq        = lastTick;
  assign ctl.boundary   = lastTick;
  assign ctl.pastLead   = (cnt >= actLead);
  assign ctl.inWin      = (cnt >= actLead) && (cnt < actTrail);
  assign ctl.strobeTick = (cnt == actStrobe);
endmodule

// File: rtl/wavefmt_dp.sv
module wavefmt_dp
  import wavefmt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  tickCtl_t ctl,
  input  logic     vecValid,
  input  logic     vecBit,
  input  logic [2:0] vecFmt,
  input  logic     vecDrive,
  input  logic     vecExpect,
  input  logic     vecMask,
  input  logic     pinIn,
  input  logic     failClr,
  output logic     pinOut,
  output logic     pinOe,
  output logic     failFlag
);
  logic       curBit, prevBit, curDrive, curExp, curMask, loaded;
  logic [2:0] curFmt;
  logic       rawOut, rawOe, mismatch;

  // vector registers, updated only at a period boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curBit   <= 1'b0;
      prevBit  <= 1'b0;
      curFmt   <= FMT_HELD;
      curDrive <= 1'b0;
      curExp   <= 1'b0;
      curMask  <= 1'b1;
      loaded   <= 1'b0;
    end else if (ctl.boundary) begin
      prevBit <= curBit;
      if (vecValid) begin
        curBit   <= vecBit;
        curFmt   <= vecFmt;
        curDrive <= vecDrive;
        curExp   <= vecExpect;
        curMask  <= vecMask;
        loaded   <= 1'b1;
      end
    end
  end

  // waveform shaping per format
  always_comb begin
    rawOe = 1'b1;
    case (fmt_e'(curFmt))
      FMT_PHIGH: rawOut = ctl.inWin & curBit;
      FMT_PLOW:  rawOut = ~ctl.inWin | curBit;
      FMT_INH: begin
        rawOut = curBit;
        rawOe  = ctl.inWin;
      end
      FMT_CMPL:  rawOut = ctl.inWin ? curBit : ~curBit;
      default:   rawOut = ctl.pastLead ? curBit : prevBit;
    endcase
  end

  assign pinOe  = loaded & curDrive & rawOe;
  assign pinOut = pinOe & rawOut;

  // compare: skipped while the driver owns the pin
  assign mismatch = ctl.strobeTick & loaded & ~curMask & ~pinOe & (pinIn != curExp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        failFlag <= 1'b0;
    else if (mismatch) failFlag <= 1'b1;
    else if (failClr)  failFlag <= 1'b0;
  end
endmodule

// File: rtl/wavefmt_pin.sv
module wavefmt_pin
  import wavefmt_pkg::*;
#(
  parameter int TICK_W     = 8,
  parameter int DEF_PERIOD = 8,
  parameter int DEF_LEAD   = 2,
  parameter int DEF_TRAIL  = 5,
  parameter int DEF_STROBE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrite,
  input  logic [TICK_W-1:0] cfgPeriod,
  input  logic [TICK_W-1:0] cfgLead,
  input  logic [TICK_W-1:0] cfgTrail,
  input  logic [TICK_W-1:0] cfgStrobe,
  output logic              cfgErr,
  input  logic              vecValid,
  input  logic              vecBit,
  input  logic [2:0]        vecFmt,
  input  logic              vecDrive,
  input  logic              vecExpect,
  input  logic              vecMask,
  output logic              nextReq,
  output logic              pinOut,
  output logic              pinOe,
  input  logic              pinIn,
  input  logic              failClr,
  output logic              failFlag
);
  tickCtl_t ctl;

  wavefmt_ctrl #(
    .TICK_W(TICK_W), .DEF_PERIOD(DEF_PERIOD), .DEF_LEAD(DEF_LEAD),
    .DEF_TRAIL(DEF_TRAIL), .DEF_STROBE(DEF_STROBE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgWrite(cfgWrite), .cfgPeriod(cfgPeriod),
    .cfgLead(cfgLead), .cfgTrail(cfgTrail), .cfgStrobe(cfgStrobe),
    .cfgErr(cfgErr), .nextReq(nextReq), .ctl(ctl)
  );

  wavefmt_dp u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .vecValid(vecValid), .vecBit(vecBit),
    .vecFmt(vecFmt), .vecDrive(vecDrive), .vecExpect(vecExpect),
    .vecMask(vecMask), .pinIn(pinIn), .failClr(failClr), .pinOut(pinOut),
    .pinOe(pinOe), .failFlag(failFlag)
  );
endmodule

// File: rtl/wavefmt_chk.sv
module wavefmt_chk #(
  parameter int TICK_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfgWrite,
  input logic [TICK_W-1:0] cfgPeriod,
  input logic [TICK_W-1:0] cfgLead,
  input logic [TICK_W-1:0] cfgTrail,
  input logic [TICK_W-1:0] cfgStrobe,
  input logic              cfgErr,
  input logic              vecValid,
  input logic              nextReq,
  input logic              pinOut,
  input logic              pinOe,
  input logic              failClr,
  input logic              failFlag
);
  logic seenLoad, wrBad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    seenLoad <= 1'b0;
    else if (nextReq && vecValid)  seenLoad <= 1'b1;
  end

  assign wrBad = (cfgPeriod < TICK_W'(2)) || (cfgLead >= cfgTrail) ||
                 (cfgTrail > cfgPeriod) || (cfgStrobe >= cfgPeriod);

  a_r1_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    nextReq |=> !nextReq);
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pinOe |-> !pinOut);
  a_r9_bad_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrite && wrBad) |=> cfgErr);
  a_r9_good_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrite && !wrBad) |=> !cfgErr);
  a_r9_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgWrite |=> $stable(cfgErr));
  a_r10_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (failFlag && !failClr) |=> failFlag);
  a_r11_no_drive_early: assert property (@(posedge clk) disable iff (!rst_n)
    !seenLoad |-> !pinOe);
endmodule

bind wavefmt_pin wavefmt_chk #(.TICK_W(TICK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfgWrite(cfgWrite), .cfgPeriod(cfgPeriod),
  .cfgLead(cfgLead), .cfgTrail(cfgTrail), .cfgStrobe(cfgStrobe),
  .cfgErr(cfgErr), .vecValid(vecValid), .nextReq(nextReq), .pinOut(pinOut),
  .pinOe(pinOe), .failClr(failClr), .failFlag(failFlag)
);

// File: tb/sim_wavefmt_pin.sv
module sim_wavefmt_pin;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgWrite = 1'b0;
  logic [TW-1:0] cfgPeriod = '0, cfgLead = '0, cfgTrail = '0, cfgStrobe = '0;
  logic cfgErr;
  logic vecValid = 1'b0, vecBit = 1'b0, vecDrive = 1'b0, vecExpect = 1'b0, vecMask = 1'b1;
  logic [2:0] vecFmt = 3'd0;
  logic nextReq, pinOut, pinOe, failFlag;
  logic pinIn = 1'b0, failClr = 1'b0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model state
  int mP = 8, mL = 2, mT = 5, mS = 6;
  bit mCur = 0, mPrev = 0, mDrive = 0, mLoaded = 0;
  int mFmt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wavefmt_pin #(.TICK_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfgWrite(cfgWrite), .cfgPeriod(cfgPeriod),
    .cfgLead(cfgLead), .cfgTrail(cfgTrail), .cfgStrobe(cfgStrobe),
    .cfgErr(cfgErr), .vecValid(vecValid), .vecBit(vecBit), .vecFmt(vecFmt),
    .vecDrive(vecDrive), .vecExpect(vecExpect), .vecMask(vecMask),
    .nextReq(nextReq), .pinOut(pinOut), .pinOe(pinOe), .pinIn(pinIn),
    .failClr(failClr), .failFlag(failFlag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // run one period; supply=0 leaves vecValid low (repeat case)
  task automatic runVec(input string req, input bit supply, input bit b, input int fmt,
                        input bit drv, input bit ex, input bit msk, input bit pin,
                        input bit expFail);
    while (!nextReq) @(negedge clk);
    if (supply) begin
      vecValid = 1'b1; vecBit = b; vecFmt = 3'(fmt); vecDrive = drv;
      vecExpect = ex; vecMask = msk;
    end
    pinIn = pin;
    mPrev = mCur;
    if (supply) begin
      mCur = b; mFmt = fmt; mDrive = drv; mLoaded = 1;
    end
    for (int t = 0; t < mP; t++) begin
      bit win, o, oe;
      @(negedge clk);
      vecValid = 1'b0;
      win = (t >= mL) && (t < mT);
      oe = 1'b1;
      case (mFmt)
        1: o = win & mCur;
        2: o = ~win | mCur;
        3: begin o = mCur; oe = win; end
        4: o = win ? mCur : ~mCur;
        default: o = (t >= mL) ? mCur : mPrev;
      endcase
      oe = oe & mDrive & mLoaded;
      o = o & oe;
      check(req, "pinOut", int'(pinOut), int'(o));
      check(req, "pinOe", int'(pinOe), int'(oe));
      check("R1", "nextReq", int'(nextReq), int'(t == mP - 1));
    end
    check(req, "failFlag", int'(failFlag), int'(expFail));
  endtask

  task automatic writeCfg(input string req, input int p, input int l, input int tr,
                          input int s, input bit expErr);
    @(negedge clk);
    cfgPeriod = TW'(p); cfgLead = TW'(l); cfgTrail = TW'(tr); cfgStrobe = TW'(s);
    cfgWrite = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0;
    check(req, "cfgErr", int'(cfgErr), int'(expErr));
    if (!expErr) begin
      mP = p; mL = l; mT = tr; mS = s;
    end
  endtask

  task automatic clearFail();
    @(negedge clk);
    failClr = 1'b1;
    @(negedge clk);
    failClr = 1'b0;
    check("R10", "failFlag after clear", int'(failFlag), 0);
  endtask

  task automatic testReset();
    check("R11", "pinOe", int'(pinOe), 0);
    check("R11", "nextReq", int'(nextReq), 0);
    check("R11", "failFlag", int'(failFlag), 0);
    check("R11", "cfgErr", int'(cfgErr), 0);
    pinIn = 1'b1;   // differs from reset expected bit; compare must not run
    while (!nextReq) @(negedge clk);
    check("R11", "failFlag before first vector", int'(failFlag), 0);
    check("R11", "pinOe before first vector", int'(pinOe), 0);
  endtask

  task automatic testHeld();
    runVec("R2", 1, 1, 0, 1, 0, 1, 0, 0);
    runVec("R2", 1, 0, 0, 1, 0, 1, 0, 0);
    runVec("R2", 1, 0, 0, 1, 0, 1, 0, 0);
    runVec("R2", 1, 1, 7, 1, 0, 1, 0, 0);   // unused code behaves as held
  endtask

  task automatic testPulses();
    runVec("R3", 1, 1, 1, 1, 0, 1, 0, 0);
    runVec("R3", 1, 0, 1, 1, 0, 1, 0, 0);
    runVec("R4", 1, 0, 2, 1, 0, 1, 0, 0);
    runVec("R4", 1, 1, 2, 1, 0, 1, 0, 0);
    runVec("R5", 1, 1, 3, 1, 0, 1, 0, 0);
    runVec("R5", 1, 0, 3, 1, 0, 1, 0, 0);
    runVec("R6", 1, 1, 4, 1, 0, 1, 0, 0);
    runVec("R6", 1, 0, 4, 1, 0, 1, 0, 0);
  endtask

  task automatic testRepeat();
    runVec("R8", 0, 0, 0, 0, 0, 0, 0, 0);
    runVec("R8", 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic testCompare();
    clearFail();
    runVec("R7", 1, 1, 1, 0, 1, 0, 1, 0);   // receive, match
    runVec("R10", 1, 0, 0, 0, 1, 1, 0, 0);  // masked mismatch
    runVec("R10", 1, 0, 0, 0, 1, 0, 0, 1);  // real mismatch
    runVec("R10", 1, 1, 0, 1, 0, 0, 1, 1);  // driving: skipped, flag sticky
    clearFail();
    runVec("R10", 1, 0, 0, 1, 1, 0, 0, 0);  // driving 0, expect 1: skipped
  endtask

  task automatic testConfig();
    writeCfg("R9", 8, 5, 5, 6, 1);          // start >= end
    runVec("R9", 1, 1, 1, 1, 0, 1, 0, 0);   // old window kept
    writeCfg("R9", 6, 1, 4, 3, 0);
    runVec("R9", 1, 1, 1, 1, 0, 1, 0, 0);
    runVec("R9", 1, 0, 4, 1, 0, 1, 0, 0);
    writeCfg("R9", 6, 1, 7, 3, 1);          // end > period
    writeCfg("R9", 6, 1, 4, 6, 1);          // strobe >= period
    writeCfg("R9", 1, 0, 1, 0, 1);          // period < 2
    runVec("R9", 1, 0, 2, 1, 0, 1, 0, 0);
    runVec("R10", 1, 0, 0, 0, 0, 0, 1, 1);  // strobe at new tick 3
    clearFail();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testHeld();
    testPulses();
    testRepeat();
    testCompare();
    testConfig();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule